// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic core of a small 8-bit controller, together with the status register that the core's flags land in. One operand comes from the accumulator and the other from data memory or an immediate field. A 5-bit operation code picks the function. The result and the skip decision for conditional-skip instructions are produced combinationally in the same cycle. The carry-in for carry-using operations is the C bit already held in the status register.

On a clock edge with the execute strobe high, the flags that the selected operation affects are written into the status register. Flags that the operation does not affect keep their values. Software may also write the register as an ordinary data location. That write changes the four arithmetic flags but leaves the power-down and time-out flags alone. Those two flags move only on reset and on three event inputs: watchdog overflow, watchdog clear, and halt entry. The register is never saved automatically on interrupt entry or on a call. Any saving is the job of the surrounding software.

Top module: `alu8_flags`

## Requirements
- R1: With the codes of R12, ADD gives acc+mem and ADC gives acc+mem+C. SUB gives acc-mem and SBC gives acc-mem-(1-C). In every case `result` is the low 8 bits. C is the carry out of bit 7, so after a subtraction C=1 means no borrow occurred.
- R2: The four add/subtract operations also update the other arithmetic flags. AC is the carry out of bit 3 (for a subtraction, 1 when the low nibble needs no borrow). OV is 1 when the signed 8-bit result overflows. Z is 1 when the result is zero.
- R3: AND, OR and XOR combine acc with mem, and CPL gives the bitwise inverse of mem. These four operations update Z and leave C, AC and OV unchanged.
- R4: RL and RR rotate mem by one bit, left and right respectively, wrapping the end bit around, and leave the flags unchanged. RLC and RRC rotate mem through C: the bit shifted out becomes the new C and the old C fills the vacated bit.
- R5: INC gives mem+1 and DEC gives mem-1, both modulo 256. They update only Z.
- R6: DAA works on acc and proceeds in order. (1) It adds 06h when acc's low nibble exceeds 9 or AC=1. (2) It then adds 60h when that sum carried past bit 7, or its high nibble exceeds 9, or C=1. (3) It sets C to 1 exactly when step 2 added 60h, and otherwise sets C to 0. No other flag changes.
- R7: `skip` is 1 in four cases: for SZ when mem is 0, for SNZ when mem is non-zero, for SIZ when mem+1 wraps to 0, and for SDZ when mem-1 is 0. SZ and SNZ return mem. SIZ and SDZ return mem+1 and mem-1. None of these four changes a flag. For every other code `skip` is 0.
- R8: The status register layout is C=bit0, AC=bit1, Z=bit2, OV=bit3, PDF=bit4, TO=bit5. Bits 7:6 always read 0. After reset the whole register is 00h.
- R9: When `staWrEn` is high, bits 3:0 of `staWrData` load C, AC, Z and OV at the next edge. Bits 7:4 of the write are ignored, so PDF and TO keep their values. If a write and an execute arrive in the same cycle, the write wins.
- R10: A watchdog overflow sets TO. A halt event sets PDF and clears TO. A watchdog clear clears PDF and TO. For TO, overflow takes priority over halt or clear. For PDF, halt takes priority over clear.
- R11: `result` and `skip` follow the inputs combinationally. Flags change only at a clock edge where `exec` is high (or at a write, R9). With `exec` low the flags hold.
- R12: Operation codes: ADD=0, ADC=1, SUB=2, SBC=3, DAA=4, AND=5, OR=6, XOR=7, CPL=8, RL=9, RR=10, RLC=11, RRC=12, INC=13, DEC=14, SZ=15, SNZ=16, SIZ=17, SDZ=18, MOV=19 (MOV returns mem, changes no flag, and does not skip). Unlisted codes behave like MOV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-up reset |
| exec | input | 1 | Commit the current operation's flags at the next edge |
| opCode | input | 5 | Operation select (R12) |
| accIn | input | 8 | Accumulator operand |
| memIn | input | 8 | Memory or immediate operand |
| staWrEn | input | 1 | Data-bus write to the status register |
| staWrData | input | 8 | Data-bus write value |
| wdtOverflow | input | 1 | Watchdog overflow event |
| clrWdt | input | 1 | Clear-watchdog instruction event |
| haltEvt | input | 1 | Halt instruction event |
| result | output | 8 | Operation result |
| skip | output | 1 | Skip the next instruction |
| statusOut | output | 8 | Status register contents |

## Verification
`result` and `skip` are due in the same cycle as their operands. The bench drives operands just after a falling edge and samples these two outputs 1 ns later, before the next rising edge. Flag updates, status writes and the power/watchdog events appear on `statusOut` after exactly one rising edge, so the bench reads them at the falling edge that follows. Before each vector, one preceding cycle writes a known flag pattern, so every expected flag can be derived from the previous state plus the operation alone.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW  = 8;
  localparam int NIB = DW / 2;
  localparam int OPW = 5;

  localparam logic [NIB-1:0] DEC_LIMIT = NIB'(9);
  localparam logic [DW:0]    LOW_FIX   = (DW+1)'(6);
  localparam logic [DW-1:0]  HIGH_FIX  = DW'(8'h60);

  localparam int BIT_C   = 0;
  localparam int BIT_AC  = 1;
  localparam int BIT_Z   = 2;
  localparam int BIT_OV  = 3;
  localparam int BIT_PDF = 4;
  localparam int BIT_TO  = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_DAA = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
    OP_CPL = 5'd8,  OP_RL  = 5'd9,  OP_RR  = 5'd10, OP_RLC = 5'd11,
    OP_RRC = 5'd12, OP_INC = 5'd13, OP_DEC = 5'd14, OP_SZ  = 5'd15,
    OP_SNZ = 5'd16, OP_SIZ = 5'd17, OP_SDZ = 5'd18, OP_MOV = 5'd19
  } aluOp_e;

  typedef enum logic [2:0] {
    U_ARITH, U_DAA, U_LOGIC, U_ROT, U_INCDEC, U_PASS
  } unit_e;

  typedef enum logic [1:0] {
    SK_NONE, SK_ZERO, SK_NZERO
  } skipMode_e;

  // strobes from control into the datapath
  typedef struct packed {
    unit_e     unit;
    logic      subtract;
    logic      useCarry;
    logic [1:0] subOp;     // logic kind / rotate dir / inc-dec
    logic      thruCarry;
    skipMode_e skipMode;
  } dpCtl_t;

  // strobes from control into the status register
  typedef struct packed {
    logic updC;
    logic updAC;
    logic updZ;
    logic updOV;
  } flagCtl_t;
endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [OPW-1:0] opCode,
  output dpCtl_t         dpCtl,
  output flagCtl_t       flCtl
);
  always_comb begin
    dpCtl      = '0;
    dpCtl.unit = U_PASS;
    flCtl      = '0;
    case (opCode)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        dpCtl.unit     = U_ARITH;
        dpCtl.subtract = (opCode == OP_SUB) || (opCode == OP_SBC);
        dpCtl.useCarry = (opCode == OP_ADC) || (opCode == OP_SBC);
        flCtl          = '{updC: 1'b1, updAC: 1'b1, updZ: 1'b1, updOV: 1'b1};
      end
      OP_DAA: begin
        dpCtl.unit  = U_DAA;
        flCtl.updC  = 1'b1;
      end
      OP_AND: begin dpCtl.unit = U_LOGIC; dpCtl.subOp = 2'd0; flCtl.updZ = 1'b1; end
      OP_OR:  begin dpCtl.unit = U_LOGIC; dpCtl.subOp = 2'd1; flCtl.updZ = 1'b1; end
      OP_XOR: begin dpCtl.unit = U_LOGIC; dpCtl.subOp = 2'd2; flCtl.updZ = 1'b1; end
      OP_CPL: begin dpCtl.unit = U_LOGIC; dpCtl.subOp = 2'd3; flCtl.updZ = 1'b1; end
      OP_RL:  begin dpCtl.unit = U_ROT; dpCtl.subOp = 2'd0; end
      OP_RR:  begin dpCtl.unit = U_ROT; dpCtl.subOp = 2'd1; end
      OP_RLC: begin
        dpCtl.unit = U_ROT; dpCtl.subOp = 2'd0; dpCtl.thruCarry = 1'b1;
        flCtl.updC = 1'b1;
      end
      OP_RRC: begin
        dpCtl.unit = U_ROT; dpCtl.subOp = 2'd1; dpCtl.thruCarry = 1'b1;
        flCtl.updC = 1'b1;
      end
      OP_INC: begin dpCtl.unit = U_INCDEC; dpCtl.subOp = 2'd0; flCtl.updZ = 1'b1; end
      OP_DEC: begin dpCtl.unit = U_INCDEC; dpCtl.subOp = 2'd1; flCtl.updZ = 1'b1; end
      OP_SZ:  begin dpCtl.unit = U_PASS; dpCtl.skipMode = SK_ZERO; end
      OP_SNZ: begin dpCtl.unit = U_PASS; dpCtl.skipMode = SK_NZERO; end
      OP_SIZ: begin dpCtl.unit = U_INCDEC; dpCtl.subOp = 2'd0; dpCtl.skipMode = SK_ZERO; end
      OP_SDZ: begin dpCtl.unit = U_INCDEC; dpCtl.subOp = 2'd1; dpCtl.skipMode = SK_ZERO; end
      default: begin dpCtl.unit = U_PASS; end
    endcase
  end
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
(
  input  dpCtl_t        ctl,
  input  logic [DW-1:0] accIn,
  input  logic [DW-1:0] memIn,
  input  logic          carryIn,
  input  logic          auxIn,
  output logic [DW-1:0] result,
  output logic          newC,
  output logic          newAC,
  output logic          newZ,
  output logic          newOV,
  output logic          skip
);
  // adder shared by the four add/subtract codes
  logic [DW-1:0] bOp;
  logic          cin;
  logic [NIB:0]  lowSum;
  logic [DW:0]   fullSum;

  assign bOp     = ctl.subtract ? ~memIn : memIn;
  assign cin     = ctl.useCarry ? carryIn : ctl.subtract;
  assign lowSum  = {1'b0, accIn[NIB-1:0]} + {1'b0, bOp[NIB-1:0]} + {{NIB{1'b0}}, cin};
  assign fullSum = {1'b0, accIn} + {1'b0, bOp} + {{DW{1'b0}}, cin};

  // decimal adjust, low correction first, then high
  logic          lowAdj;
  logic          highAdj;
  logic [DW:0]   daaStage;
  logic [DW-1:0] daaRes;

  assign lowAdj   = (accIn[NIB-1:0] > DEC_LIMIT) || auxIn;
  assign daaStage = {1'b0, accIn} + (lowAdj ? LOW_FIX : '0);
  assign highAdj  = daaStage[DW] || (daaStage[DW-1:NIB] > DEC_LIMIT) || carryIn;
  assign daaRes   = daaStage[DW-1:0] + (highAdj ? HIGH_FIX : '0);

  // rotator
  logic [DW-1:0] rotRes;
  logic          rotC;

  always_comb begin
    if (ctl.subOp[0] == 1'b0) begin
      rotRes = {memIn[DW-2:0], ctl.thruCarry ? carryIn : memIn[DW-1]};
      rotC   = memIn[DW-1];
    end else begin
      rotRes = {ctl.thruCarry ? carryIn : memIn[0], memIn[DW-1:1]};
      rotC   = memIn[0];
    end
  end

  // logic unit and inc/dec
  logic [DW-1:0] logRes;
  logic [DW-1:0] stepRes;

  always_comb begin
    case (ctl.subOp)
      2'd0:    logRes = accIn & memIn;
      2'd1:    logRes = accIn | memIn;
      2'd2:    logRes = accIn ^ memIn;
      default: logRes = ~memIn;
    endcase
  end

  assign stepRes = ctl.subOp[0] ? (memIn - DW'(1)) : (memIn + DW'(1));

  always_comb begin
    case (ctl.unit)
      U_ARITH:  result = fullSum[DW-1:0];
      U_DAA:    result = daaRes;
      U_LOGIC:  result = logRes;
      U_ROT:    result = rotRes;
      U_INCDEC: result = stepRes;
      default:  result = memIn;
    endcase
  end

  always_comb begin
    case (ctl.unit)
      U_ARITH: newC = fullSum[DW];
      U_DAA:   newC = highAdj;
      U_ROT:   newC = rotC;
      default: newC = carryIn;
    endcase
  end

  assign newAC = lowSum[NIB];
  assign newOV = (accIn[DW-1] == bOp[DW-1]) && (fullSum[DW-1] != accIn[DW-1]);
  assign newZ  = (result == '0);

  always_comb begin
    case (ctl.skipMode)
      SK_ZERO:  skip = (result == '0);
      SK_NZERO: skip = (result != '0);
      default:  skip = 1'b0;
    endcase
  end

  always_comb begin
    if (ctl.skipMode == SK_NONE) begin
      AST_SKIP_GATED: assert (!skip); // R7
    end
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          exec,
  input  flagCtl_t      flCtl,
  input  logic          newC,
  input  logic          newAC,
  input  logic          newZ,
  input  logic          newOV,
  input  logic          staWrEn,
  input  logic [DW-1:0] staWrData,
  input  logic          wdtOverflow,
  input  logic          clrWdt,
  input  logic          haltEvt,
  output logic          carryOut,
  output logic          auxOut,
  output logic [DW-1:0] statusOut
);
  logic flagC, flagAC, flagZ, flagOV, flagPdf, flagTo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagC   <= 1'b0;
      flagAC  <= 1'b0;
      flagZ   <= 1'b0;
      flagOV  <= 1'b0;
      flagPdf <= 1'b0;
      flagTo  <= 1'b0;
    end else begin
      if (staWrEn) begin
        flagC  <= staWrData[BIT_C];
        flagAC <= staWrData[BIT_AC];
        flagZ  <= staWrData[BIT_Z];
        flagOV <= staWrData[BIT_OV];
      end else if (exec) begin
        if (flCtl.updC)  flagC  <= newC;
        if (flCtl.updAC) flagAC <= newAC;
        if (flCtl.updZ)  flagZ  <= newZ;
        if (flCtl.updOV) flagOV <= newOV;
      end
      if (wdtOverflow)          flagTo <= 1'b1;
      else if (haltEvt || clrWdt) flagTo <= 1'b0;
      if (haltEvt)              flagPdf <= 1'b1;
      else if (clrWdt)          flagPdf <= 1'b0;
    end
  end

  always_comb begin
    statusOut          = '0;
    statusOut[BIT_C]   = flagC;
    statusOut[BIT_AC]  = flagAC;
    statusOut[BIT_Z]   = flagZ;
    statusOut[BIT_OV]  = flagOV;
    statusOut[BIT_PDF] = flagPdf;
    statusOut[BIT_TO]  = flagTo;
  end

  assign carryOut = flagC;
  assign auxOut   = flagAC;

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    staWrEn |=> statusOut[3:0] == $past(staWrData[3:0])); // R9

  AST_WRITE_PROTECTS: assert property (@(posedge clk) disable iff (!rstN)
    staWrEn && !wdtOverflow && !haltEvt && !clrWdt && (staWrData[7:4] != 4'h0)
    |=> $stable(statusOut[5:4]) && statusOut[7:6] == 2'b00); // R9

  AST_HALT_SETS_PDF: assert property (@(posedge clk) disable iff (!rstN)
    haltEvt && !wdtOverflow |=> statusOut[BIT_PDF] && !statusOut[BIT_TO]); // R10

  AST_OVF_SETS_TO: assert property (@(posedge clk) disable iff (!rstN)
    wdtOverflow |=> statusOut[BIT_TO]); // R10

  AST_CLR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    clrWdt && !haltEvt && !wdtOverflow |=> !statusOut[BIT_PDF] && !statusOut[BIT_TO]); // R10

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !exec && !staWrEn |=> $stable(statusOut[3:0])); // R11

  AST_UNTOUCHED_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    exec && !staWrEn && !flCtl.updC |=> $stable(carryOut)); // R3
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          exec,
  input  logic [4:0]    opCode,
  input  logic [7:0]    accIn,
  input  logic [7:0]    memIn,
  input  logic          staWrEn,
  input  logic [7:0]    staWrData,
  input  logic          wdtOverflow,
  input  logic          clrWdt,
  input  logic          haltEvt,
  output logic [7:0]    result,
  output logic          skip,
  output logic [7:0]    statusOut
);
  dpCtl_t   dpCtl;
  flagCtl_t flCtl;
  logic     newC, newAC, newZ, newOV;
  logic     carryCur, auxCur;

  alu8_ctrl u_ctrl (
    .opCode (opCode),
    .dpCtl  (dpCtl),
    .flCtl  (flCtl)
  );

  alu8_datapath u_dp (
    .ctl     (dpCtl),
    .accIn   (accIn),
    .memIn   (memIn),
    .carryIn (carryCur),
    .auxIn   (auxCur),
    .result  (result),
    .newC    (newC),
    .newAC   (newAC),
    .newZ    (newZ),
    .newOV   (newOV),
    .skip    (skip)
  );

  alu8_status u_status (
    .clk         (clk),
    .rstN        (rstN),
    .exec        (exec),
    .flCtl       (flCtl),
    .newC        (newC),
    .newAC       (newAC),
    .newZ        (newZ),
    .newOV       (newOV),
    .staWrEn     (staWrEn),
    .staWrData   (staWrData),
    .wdtOverflow (wdtOverflow),
    .clrWdt      (clrWdt),
    .haltEvt     (haltEvt),
    .carryOut    (carryCur),
    .auxOut      (auxCur),
    .statusOut   (statusOut)
  );
endmodule

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       exec = 1'b0;
  logic [4:0] opCode = 5'd19;
  logic [7:0] accIn = 8'h00;
  logic [7:0] memIn = 8'h00;
  logic       staWrEn = 1'b0;
  logic [7:0] staWrData = 8'h00;
  logic       wdtOverflow = 1'b0;
  logic       clrWdt = 1'b0;
  logic       haltEvt = 1'b0;
  logic [7:0] result;
  logic       skip;
  logic [7:0] statusOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  alu8_flags u_dut (
    .clk(clk), .rstN(rstN), .exec(exec), .opCode(opCode),
    .accIn(accIn), .memIn(memIn), .staWrEn(staWrEn), .staWrData(staWrData),
    .wdtOverflow(wdtOverflow), .clrWdt(clrWdt), .haltEvt(haltEvt),
    .result(result), .skip(skip), .statusOut(statusOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // expected behaviour from the requirements; fl = {OV,Z,AC,C}
  function automatic void model(input int op, input int a, input int m, input logic [3:0] pre,
                                output int res, output logic [3:0] fl, output logic sk);
    int c, s, bw, cin, t, lo, hi, ss;
    logic hadj;
    c = int'(pre[0]);
    fl = pre;
    sk = 1'b0;
    res = m;
    case (op)
      0, 1: begin
        cin = (op == 1) ? c : 0;
        s = a + m + cin;
        res = s & 255;
        fl[0] = (s > 255);
        fl[1] = (((a & 15) + (m & 15) + cin) > 15);
        ss = sgn(a) + sgn(m) + cin;
        fl[3] = (ss > 127) || (ss < -128);
        fl[2] = (res == 0);
      end
      2, 3: begin
        bw = (op == 3) ? (1 - c) : 0;
        s = a - m - bw;
        res = s & 255;
        fl[0] = (s >= 0);
        fl[1] = (((a & 15) - (m & 15) - bw) >= 0);
        ss = sgn(a) - sgn(m) - bw;
        fl[3] = (ss > 127) || (ss < -128);
        fl[2] = (res == 0);
      end
      4: begin
        lo = a & 15;
        t = a + ((lo > 9 || pre[1]) ? 6 : 0);
        hi = (t >> 4) & 15;
        hadj = (t > 255) || (hi > 9) || pre[0];
        res = (t + (hadj ? 96 : 0)) & 255;
        fl[0] = hadj;
      end
      5: begin res = a & m; fl[2] = (res == 0); end
      6: begin res = a | m; fl[2] = (res == 0); end
      7: begin res = a ^ m; fl[2] = (res == 0); end
      8: begin res = (~m) & 255; fl[2] = (res == 0); end
      9:  res = ((m << 1) | (m >> 7)) & 255;
      10: res = ((m >> 1) | ((m & 1) << 7)) & 255;
      11: begin res = ((m << 1) | c) & 255; fl[0] = (m >= 128); end
      12: begin res = (m >> 1) | (c << 7); fl[0] = m[0]; end
      13: begin res = (m + 1) & 255; fl[2] = (res == 0); end
      14: begin res = (m + 255) & 255; fl[2] = (res == 0); end
      15: sk = (m == 0);
      16: sk = (m != 0);
      17: begin res = (m + 1) & 255; sk = (res == 0); end
      18: begin res = (m + 255) & 255; sk = (res == 0); end
      default: res = m;
    endcase
  endfunction

  task automatic runOp(input string req, input int op, input int a, input int m, input logic [3:0] pre);
    int expRes;
    logic [3:0] expFl;
    logic expSk;
    @(negedge clk);
    staWrEn = 1'b1; staWrData = {4'h0, pre}; exec = 1'b0;
    @(negedge clk);
    staWrEn = 1'b0; opCode = 5'(op); accIn = 8'(a); memIn = 8'(m); exec = 1'b1;
    #1;
    model(op, a, m, pre, expRes, expFl, expSk);
    chk({req, " result"}, int'(result), expRes);
    chk({req, " skip"}, int'(skip), int'(expSk));
    @(negedge clk);
    exec = 1'b0;
    #1;
    chk({req, " flags"}, int'(statusOut[3:0]), int'(expFl));
  endtask

  // one-cycle event/write pulse, then check the whole register
  task automatic pulse(input string req, input logic wr, input logic [7:0] wd,
                       input logic ov, input logic cl, input logic ht, input int expStatus);
    @(negedge clk);
    staWrEn = wr; staWrData = wd; wdtOverflow = ov; clrWdt = cl; haltEvt = ht;
    @(negedge clk);
    staWrEn = 1'b0; wdtOverflow = 1'b0; clrWdt = 1'b0; haltEvt = 1'b0;
    #1;
    chk(req, int'(statusOut), expStatus);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL R11 watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset value", int'(statusOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk("R8 after reset", int'(statusOut), 0);

    // R1 R2: add/subtract family
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 256; a++)
        for (int j = 0; j < 16; j++)
          runOp((op < 2) ? "R1 R2 add" : "R1 R2 sub", op, a, j * 17,
                4'(a) ^ 4'(j) ^ 4'(op));

    // R3: two-operand logic, C/AC/OV preset to catch disturbance
    for (int op = 5; op < 8; op++)
      for (int a = 0; a < 256; a++)
        for (int j = 0; j < 16; j++)
          runOp("R3 logic", op, a, j * 17, (j[0]) ? 4'b1011 : 4'b0100);

    // R3 R4 R5 R7 R12: single-operand codes
    for (int op = 8; op < 20; op++)
      for (int m = 0; m < 256; m++)
        for (int p = 0; p < 2; p++)
          runOp((op == 8) ? "R3 cpl" : (op < 13) ? "R4 rotate" :
                (op < 15) ? "R5 incdec" : (op < 19) ? "R7 skip" : "R12 mov",
                op, 8'h5A, m, p[0] ? 4'b1011 : 4'b0100);

    // R6: decimal adjust over every acc and every C/AC pair
    for (int a = 0; a < 256; a++)
      for (int p = 0; p < 4; p++)
        runOp("R6 daa", 4, a, 8'h33, {2'b00, p[1], p[0]});

    // R8 R9 R10: protected bits and event rules
    pulse("R9 write masks upper", 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h0F);
    pulse("R10 halt", 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h1F);
    pulse("R10 overflow", 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h3F);
    pulse("R9 write keeps TO PDF", 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h30);
    pulse("R10 clear", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    pulse("R10 overflow beats halt", 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h30);
    pulse("R10 halt beats clear", 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h10);
    pulse("R10 clear again", 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00);

    // R11: no exec -> combinational result, flags hold
    @(negedge clk);
    opCode = 5'd0; accIn = 8'hFF; memIn = 8'h01; exec = 1'b0;
    #1;
    chk("R11 comb result", int'(result), 0);
    @(negedge clk);
    #1;
    chk("R11 flags hold", int'(statusOut), 0);

    // R9: write and exec in one cycle, write wins
    @(negedge clk);
    exec = 1'b1; staWrEn = 1'b1; staWrData = 8'h08;
    @(negedge clk);
    exec = 1'b0; staWrEn = 1'b0;
    #1;
    chk("R9 write over exec", int'(statusOut), 8'h08);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule